// File: doc/BRIEF.md
# Line Pulse Timer

This block produces the three line-rate pulses that an image-sensor front end needs on every line. These are a horizontal blanking pulse, a pixel blanking pulse and an optical-black clamp pulse. The timing comes from a horizontal pixel counter that advances on every pixel clock. The counter does not restart on the falling edge of the horizontal sync input. It restarts a fixed pipeline delay after that edge, which is twelve clocks by default. Software therefore programs each transition as the desired pixel position minus the delay. The delay window just after the sync edge cannot hold any transition.

Each pulse is described by two position registers. The first sets the point where the pulse turns active and the second sets the point where it turns inactive. The horizontal blanking pulse has one register pair for even lines and one for odd lines. A line-parity bit picks the pair. It flips at every counter restart and returns to even after a vertical sync falling edge. Writes go into a shadow bank and reach the working copy only at the next counter restart, so a line never runs on a mix of old and new values. If no sync arrives, the counter stops at its maximum value, and no transition repeats.

Top module: `line_pulse_timer`

## Requirements
- R1: After reset, the outputs rest at their inactive levels and show no transition until the first counter restart.
- R2: A falling edge of hd_i is taken at the first rising clock edge that samples hd_i low after sampling it high. The counter is 0 after the twelfth rising edge that follows that edge. A transition programmed with value V appears at the output right after the rising edge that is V+12 edges past the sync edge.
- R3: Inside a line, the output turns active when the count equals the first register of its pair and inactive when the count equals the second register. When both registers hold the same value, the output stays inactive.
- R4: hblk_o is active high. pblk_n_o and clamp_n_o are active low. Every counter restart forces all three outputs to their inactive level.
- R5: The line parity flips at each counter restart. Even lines use the hblk pair at addresses 0 and 1, and odd lines use the pair at addresses 2 and 3.
- R6: A falling edge of vd_i makes the next counter restart start an even line. If the edge falls in the same cycle as a restart, that line itself is even. The first line after reset is even.
- R7: A new hd_i falling edge during a running delay restarts the delay. Only one counter restart follows, twelve edges after the newest falling edge.
- R8: The counter stops at its maximum value (8191 with the default 13-bit width) and does not wrap. An output that has settled stays unchanged until the next restart.
- R9: A register write changes only the shadow bank. The shadow bank is copied into the working bank at a counter restart, including a write that is sampled on that same edge. A write made during a line does not change that line.
- R10: A register value of 0 causes no transition, because the restart in the same cycle takes priority.
- R11: Register map by wr_addr_i: 0 and 1 are the even-line hblk first and second positions, 2 and 3 are the odd-line hblk pair, 4 and 5 are the pblk pair, and 6 and 7 are the clamp pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_i | input | 1 | Horizontal sync; its falling edge starts the restart delay |
| vd_i | input | 1 | Vertical sync; its falling edge sets the next line to even |
| wr_en_i | input | 1 | Write strobe for the shadow position bank |
| wr_addr_i | input | 3 | Register address (see R11) |
| wr_data_i | input | 13 | Position value to write |
| hblk_o | output | 1 | Horizontal blanking pulse, active high |
| pblk_n_o | output | 1 | Pixel blanking pulse, active low |
| clamp_n_o | output | 1 | Clamp pulse, active low |

## Verification
A vertical sync falling edge and a counter restart can land in the same clock. In that case the parity clear has to beat the usual parity flip. The bench first runs an even line, so a plain flip would give an odd line. It then drops vd_i so that the falling edge is sampled on the same edge as the counter restart. The result is judged from the hblk output: every pixel of that line must follow the even-line pair, and the even and odd pairs are programmed to different windows so that the two cases can be told apart.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int NUM_SLOT  = 8;
    localparam int NUM_PULSE = 3;

    localparam int PULSE_HBLK  = 0;
    localparam int PULSE_PBLK  = 1;
    localparam int PULSE_CLAMP = 2;

    // Slot of the first position register for a pulse; the second follows it.
    function automatic int first_slot(input int pulse, input logic odd_line);
        int slot;
        case (pulse)
            PULSE_HBLK: slot = odd_line ? 2 : 0;
            PULSE_PBLK: slot = 4;
            default:    slot = 6;
        endcase
        return slot;
    endfunction

    function automatic bit active_low(input int pulse);
        return pulse != PULSE_HBLK;
    endfunction

endpackage

// File: rtl/lpt_start_delay.sv
module lpt_start_delay #(
    parameter int PIPE_DLY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hd_i,
    input  logic vd_i,
    output logic line_start_o,
    output logic vd_fall_o
);
    localparam int DLY_W = (PIPE_DLY > 1) ? $clog2(PIPE_DLY) : 1;
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(PIPE_DLY - 1);

    typedef struct packed {
        logic             hd;
        logic             vd;
        logic             busy;
        logic [DLY_W-1:0] dly;
    } dly_t;

    dly_t st_d, st_q;
    logic hd_fall;
    logic expire;

    assign hd_fall = st_q.hd & ~hd_i;
    assign expire  = st_q.busy && (st_q.dly == '0);

    always_comb begin
        st_d    = st_q;
        st_d.hd = hd_i;
        st_d.vd = vd_i;
        if (hd_fall) begin
            // the newest edge always restarts the delay
            st_d.busy = 1'b1;
            st_d.dly  = DLY_LOAD;
        end else if (expire) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.dly = st_q.dly - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_start_o = expire & ~hd_fall;
    assign vd_fall_o    = st_q.vd & ~vd_i;

endmodule

// File: rtl/lpt_regbank.sv
module lpt_regbank #(
    parameter int DATA_W = 13,
    parameter int ADDR_W = 3
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en_i,
    input  logic [ADDR_W-1:0]                            wr_addr_i,
    input  logic [DATA_W-1:0]                            wr_data_i,
    input  logic                                         load_i,
    output logic [lpt_pkg::NUM_SLOT-1:0][DATA_W-1:0]     active_o
);
    localparam int NSLOT = lpt_pkg::NUM_SLOT;
    localparam int SEL_W = $clog2(NSLOT);

    typedef struct packed {
        logic [NSLOT-1:0][DATA_W-1:0] shadow;
        logic [NSLOT-1:0][DATA_W-1:0] active;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  in_range;

    generate
        if (ADDR_W > SEL_W) begin : g_wide
            assign in_range = ~|wr_addr_i[ADDR_W-1:SEL_W];
        end else begin : g_exact
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && in_range) begin
            bank_d.shadow[wr_addr_i[SEL_W-1:0]] = wr_data_i;
        end
        if (load_i) begin
            // a write on the restart edge is already part of the copy
            bank_d.active = bank_d.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active_o = bank_q.active;

endmodule

// File: rtl/lpt_pulse.sv
module lpt_pulse #(
    parameter int CNT_W    = 13,
    parameter bit ACT_LOW  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] first_i,
    input  logic [CNT_W-1:0] second_i,
    output logic             lvl_o
);
    typedef struct packed {
        logic act;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.act = 1'b0;
        end else if (step_i) begin
            if (cnt_i == first_i) begin
                st_d.act = 1'b1;
            end
            // the second position wins when both match
            if (cnt_i == second_i) begin
                st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.act ^ ACT_LOW;

endmodule

// File: rtl/line_pulse_timer.sv
module line_pulse_timer #(
    parameter int CNT_W    = 13,
    parameter int PIPE_DLY = 12,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_i,
    input  logic              vd_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic              hblk_o,
    output logic              pblk_n_o,
    output logic              clamp_n_o
);
    localparam int NSLOT  = lpt_pkg::NUM_SLOT;
    localparam int NPULSE = lpt_pkg::NUM_PULSE;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             par;
        logic             pend;
    } line_t;

    line_t st_d, st_q;
    logic  line_start;
    logic  vd_fall;
    logic  step;
    logic  [NSLOT-1:0][CNT_W-1:0] act_regs;
    logic  [NPULSE-1:0][CNT_W-1:0] first_w;
    logic  [NPULSE-1:0][CNT_W-1:0] second_w;
    logic  [NPULSE-1:0] lvl;
    logic  [CNT_W-1:0] cnt_q;
    logic  par_q;

    lpt_start_delay #(
        .PIPE_DLY(PIPE_DLY)
    ) u_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .hd_i        (hd_i),
        .vd_i        (vd_i),
        .line_start_o(line_start),
        .vd_fall_o   (vd_fall)
    );

    lpt_regbank #(
        .DATA_W(CNT_W),
        .ADDR_W(ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .load_i   (line_start),
        .active_o (act_regs)
    );

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (line_start) begin
            st_d.cnt  = '0;
            st_d.par  = (st_q.pend | vd_fall) ? 1'b0 : ~st_q.par;
            st_d.pend = 1'b0;
        end else begin
            if (vd_fall) begin
                st_d.pend = 1'b1;
            end
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
                step     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_MAX;
            st_q.par  <= 1'b0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign par_q = st_q.par;

    generate
        for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
            localparam bit AL = lpt_pkg::active_low(g);

            always_comb begin
                first_w[g]  = act_regs[lpt_pkg::first_slot(g, st_q.par)];
                second_w[g] = act_regs[lpt_pkg::first_slot(g, st_q.par) + 1];
            end

            lpt_pulse #(
                .CNT_W  (CNT_W),
                .ACT_LOW(AL)
            ) u_pulse (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear_i (line_start),
                .step_i  (step),
                .cnt_i   (st_d.cnt),
                .first_i (first_w[g]),
                .second_i(second_w[g]),
                .lvl_o   (lvl[g])
            );
        end
    endgenerate

    assign hblk_o    = lvl[lpt_pkg::PULSE_HBLK];
    assign pblk_n_o  = lvl[lpt_pkg::PULSE_PBLK];
    assign clamp_n_o = lvl[lpt_pkg::PULSE_CLAMP];

endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hd_i,
    input logic             line_start,
    input logic             vd_fall,
    input logic [CNT_W-1:0] cnt_q,
    input logic             par_q,
    input logic             hblk,
    input logic             pblk_n,
    input logic             clamp_n
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_zero_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (cnt_q == '0));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_idle_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (!hblk && pblk_n && clamp_n));

    p_parity_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(par_q));

    p_vd_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && vd_fall) |=> !par_q);

    p_restart_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hd_i) |-> !line_start);

    p_hold_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && cnt_q == CMAX) |=> (cnt_q == CMAX));

    p_quiet_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && cnt_q == CMAX) |=> $stable({hblk, pblk_n, clamp_n}));

endmodule

bind line_pulse_timer lpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hd_i      (hd_i),
    .line_start(line_start),
    .vd_fall   (vd_fall),
    .cnt_q     (cnt_q),
    .par_q     (par_q),
    .hblk      (hblk_o),
    .pblk_n    (pblk_n_o),
    .clamp_n   (clamp_n_o)
);

// File: tb/sim_line_pulse_timer.sv
module sim_line_pulse_timer;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_LEN   = 150;
    localparam int NVEC       = 4;

    // per row: slots 0..7 in address order (R11)
    localparam int VEC [NVEC][8] = '{
        '{48, 88, 30, 70, 10, 40, 91, 100},
        '{48, 88, 30, 70,  5, 60, 20,  25},
        '{20, 21, 50, 90, 33, 33,  1, 120},
        '{100, 60, 2,  3,  0, 50, 119, 125}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hd = 1'b1;
    logic        vd = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic        hblk, pblk_n, clamp_n;

    int n_chk = 0;
    int n_bad = 0;
    int sh [8];
    int ac [8];
    bit par_m = 1'b1;
    bit pend_m = 1'b1;

    line_pulse_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .hd_i     (hd),
        .vd_i     (vd),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .hblk_o   (hblk),
        .pblk_n_o (pblk_n),
        .clamp_n_o(clamp_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string req, input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %0d expected %0d", req, tag, act, exp);
        end
    endtask

    // level at a given count, walked from the requirement text (R3, R10)
    function automatic bit lvl_of(input int cnt, input int f, input int s);
        bit l = 1'b0;
        for (int p = 1; p <= cnt; p++) begin
            if (p == f) l = 1'b1;
            if (p == s) l = 1'b0;
        end
        return l;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 3'(a);
        wr_data = 13'(d);
        sh[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_line(input int len, input int wr_k, input int wr_a, input int wr_d,
                            input int vd_k, input string tag);
        @(negedge clk);
        hd = 1'b1;
        @(negedge clk);
        hd = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            if (k == 12) begin
                par_m  = pend_m ? 1'b0 : ~par_m;
                pend_m = 1'b0;
                ac = sh;
            end
            if (k >= 12) begin
                check("R5", tag, int'(hblk),
                      int'(lvl_of(k - 12, ac[par_m ? 2 : 0], ac[par_m ? 3 : 1])));
                check("R4", tag, int'(pblk_n), int'(!lvl_of(k - 12, ac[4], ac[5])));
                check("R3", tag, int'(clamp_n), int'(!lvl_of(k - 12, ac[6], ac[7])));
            end
            if (k == wr_k) begin
                wr_en = 1'b1;
                wr_addr = 3'(wr_a);
                wr_data = 13'(wr_d);
                sh[wr_a] = wr_d;
            end
            if (k == vd_k) begin
                vd = 1'b0;
                pend_m = 1'b1;
            end
            if (k == vd_k + 2) vd = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            sh[i] = 0;
            ac[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: inactive levels after reset and no activity without a sync edge
        check("R1", "reset hblk", int'(hblk), 0);
        check("R1", "reset pblk", int'(pblk_n), 1);
        check("R1", "reset clamp", int'(clamp_n), 1);
        wr(6, 3);
        wr(7, 9);
        repeat (20) @(negedge clk);
        check("R1", "idle clamp", int'(clamp_n), 1);

        // table walk: R2 R3 R4 R5 R10 R11
        for (int v = 0; v < NVEC; v++) begin
            for (int a = 0; a < 8; a++) wr(a, VEC[v][a]);
            run_line(LINE_LEN, -1, 0, 0, -1, "table R11");
        end

        // R6: VD mid-line -> next line even even though a flip would give odd
        for (int a = 0; a < 8; a++) wr(a, VEC[0][a]);
        run_line(LINE_LEN, -1, 0, 0, 60, "R6 vd mid line");
        run_line(LINE_LEN, -1, 0, 0, -1, "R6 line after vd");
        run_line(LINE_LEN, -1, 0, 0, 11, "R6 vd on restart edge");

        // R9: write during a line is deferred; write on restart edge applies now
        run_line(LINE_LEN, 40, 6, 30, -1, "R9 mid-line write");
        run_line(LINE_LEN, 11, 6, 15, -1, "R9 write on restart");
        run_line(LINE_LEN, -1, 0, 0, -1, "R9 follow-up");

        // R7: second HD fall during the delay restarts it
        wr(6, 3);
        wr(7, 200);
        @(negedge clk);
        hd = 1'b1;
        @(negedge clk);
        hd = 1'b0;
        for (int j = 0; j < 30; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j == 2) hd = 1'b1;
            if (j == 4) hd = 1'b0;
            if (j == 17) begin
                par_m  = pend_m ? 1'b0 : ~par_m;
                pend_m = 1'b0;
                ac = sh;
                check("R7", "restart idle hblk", int'(hblk), 0);
                check("R7", "restart idle clamp", int'(clamp_n), 1);
            end
            if (j == 19) check("R7", "before toggle", int'(clamp_n), 1);
            if (j == 20) check("R7", "at toggle", int'(clamp_n), 0);
        end

        // R8: no wrap after saturation
        wr(6, 5);
        wr(7, 20);
        run_line(LINE_LEN, -1, 0, 0, -1, "R8 setup");
        for (int t = 0; t < 8300; t++) begin
            @(negedge clk);
            check("R8", "saturated clamp", int'(clamp_n), 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule